// File: doc/BRIEF.md
# USB host functional-state controller

This block keeps the control register of a USB host controller and the four-state machine that says what the host is doing: held in bus reset, driving resume, operational with frames running, or suspended. Software reads and writes the control and status words through a one-cycle register port. Two reset paths exist. The asynchronous hardware reset clears everything and asks for a root-hub reset. The synchronous software reset parks the machine in suspend and leaves the ownership and wake-up configuration alone.

While the machine is operational, a frame timer counts a parameterised number of clock cycles per 1 ms frame. At the end of each frame it raises a one-cycle start-of-frame strobe. That strobe sets a sticky status flag and latches the bulk-list enable for the frame that follows. Interrupt events, both external and the start-of-frame flag, are steered to either the normal interrupt output or the system-management interrupt output by one control bit. The block has no data stream, so every pin is a plain control or status level.

Top module: `usbh_fstate_ctrl`

## Requirements
- R1: The control word holds bulk enable in bit 0, the functional state in bits 2:1 (00 reset, 01 resume, 10 operational, 11 suspend), interrupt routing in bit 3 and remote-wakeup-connected in bit 4. A write to it (address 0) takes effect at the next clock edge, and reads return those bits, with all other bits zero.
- R2: After any move into operational from another state, `sof_pulse` is high for exactly one cycle: the FRAME_CYCLES-th cycle spent in operational. It repeats every FRAME_CYCLES cycles and is never high outside operational. Rewriting operational while already operational does not restart the frame.
- R3: While in suspend, `resume_det` moves the state to resume at the next edge. In any other state `resume_det` has no effect. A control write in the same cycle takes precedence.
- R4: A `sw_rst` pulse puts the state in suspend and clears bulk enable, the bulk-frame flag and the start-of-frame flag. It keeps interrupt routing and remote-wakeup-connected unchanged.
- R5: Hardware reset (`hw_rst_n` low) puts the state in reset and clears every register bit. It holds `hub_rst` high until the first clock edge after release, after which `hub_rst` is low.
- R6: `ds_rst_req` is high whenever the state is reset and low once software moves the state elsewhere.
- R7: An interrupt request exists when any `evt_in` bit or the start-of-frame flag is set. It appears on `irq` when routing is 0 and on `smi` when routing is 1, and never on both.
- R8: The start-of-frame flag (status word bit 0, address 1) is set at the edge that ends each `sof_pulse` cycle. Writing 1 to that bit clears it, unless a start-of-frame occurs in the same cycle, in which case the set wins.
- R9: `bulk_active` takes the value of bulk enable at each start-of-frame edge and holds it for the rest of the frame. A cleared enable therefore stops bulk processing only after the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| resume_det | input | 1 | Resume signaling seen on a downstream port |
| evt_in | input | N_EVT | External interrupt events |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| bulk_active | output | 1 | Bulk list may be processed in this frame |
| irq | output | 1 | Normal interrupt |
| smi | output | 1 | System-management interrupt |
| hub_rst | output | 1 | Root-hub reset request |
| ds_rst_req | output | 1 | Downstream reset-signaling request |

## Verification
The bench builds the block with FRAME_CYCLES = 16, DATA_W = 8 and N_EVT = 4. A 16-cycle frame lets it watch several whole frames cycle by cycle, including the first frame after entry to operational and a mid-frame rewrite of the state. It also places a flag-clear write exactly on a strobe cycle. The default 48000-cycle frame would leave those cases out of reach.

// File: rtl/usbh_fs_pkg.sv
package usbh_fs_pkg;
  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } fstate_e;

  localparam int CTRL_BULK_BIT  = 0;
  localparam int CTRL_FS_LO     = 1;
  localparam int CTRL_ROUTE_BIT = 3;
  localparam int CTRL_RWAKE_BIT = 4;
  localparam int CTRL_USED_BITS = 5;
  localparam int STAT_SOF_BIT   = 0;
endpackage

// File: rtl/usbh_fs_frame_timer.sv
module usbh_fs_frame_timer #(
  parameter int FRAME_CYCLES = 48000
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic in_oper,
  output logic sof
);
  localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)       cnt <= '0;
    else if (!in_oper)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign sof = in_oper && (cnt == LAST);

  // R2: strobe only while operational, and never in the first operational cycle
  a_r2_sof_only_oper: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sof |-> in_oper);
  a_r2_no_sof_on_entry: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $rose(in_oper) |-> !sof);
endmodule

// File: rtl/usbh_fs_regs.sv
module usbh_fs_regs
  import usbh_fs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              resume_det,
  input  logic              sof,
  output fstate_e           state,
  output logic              bulk_en,
  output logic              bulk_frame,
  output logic              route_smi,
  output logic              sof_flag
);
  logic rwake;
  logic ctrl_wr, stat_wr;
  logic unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == 1'b0);
  assign stat_wr = reg_wr && (reg_addr == 1'b1);
  assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_USED_BITS];

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      state      <= FS_RESET;
      bulk_en    <= 1'b0;
      bulk_frame <= 1'b0;
      route_smi  <= 1'b0;
      rwake      <= 1'b0;
      sof_flag   <= 1'b0;
    end else if (sw_rst) begin
      state      <= FS_SUSPEND;
      bulk_en    <= 1'b0;
      bulk_frame <= 1'b0;
      sof_flag   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        state     <= fstate_e'(reg_wdata[CTRL_FS_LO +: 2]);
        bulk_en   <= reg_wdata[CTRL_BULK_BIT];
        route_smi <= reg_wdata[CTRL_ROUTE_BIT];
        rwake     <= reg_wdata[CTRL_RWAKE_BIT];
      end else if (state == FS_SUSPEND && resume_det) begin
        state <= FS_RESUME;
      end
      if (sof)                                  sof_flag <= 1'b1;
      else if (stat_wr && reg_wdata[STAT_SOF_BIT]) sof_flag <= 1'b0;
      if (sof) bulk_frame <= bulk_en;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 1'b0) begin
      reg_rdata[CTRL_BULK_BIT]      = bulk_en;
      reg_rdata[CTRL_FS_LO +: 2]    = state;
      reg_rdata[CTRL_ROUTE_BIT]     = route_smi;
      reg_rdata[CTRL_RWAKE_BIT]     = rwake;
    end else begin
      reg_rdata[STAT_SOF_BIT]       = sof_flag;
    end
  end

  // R4: software reset lands in suspend
  a_r4_swrst_suspend: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |=> (state == FS_SUSPEND));
  // R3: without software action, the only state change is suspend -> resume
  a_r3_auto_from_suspend: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!ctrl_wr && !sw_rst && state != FS_SUSPEND) |=> $stable(state));
  // R8: a strobe always leaves the flag set
  a_r8_flag_sets: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sof && !sw_rst) |=> sof_flag);
  // R9: bulk frame flag only moves on a strobe or software reset
  a_r9_bulk_holds: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!sof && !sw_rst) |=> $stable(bulk_frame));
endmodule

// File: rtl/usbh_fs_irq_route.sv
module usbh_fs_irq_route #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             sof_flag,
  input  logic             route_smi,
  output logic             irq,
  output logic             smi
);
  logic pending;

  assign pending = (|evt_in) || sof_flag;
  assign irq = pending && !route_smi;
  assign smi = pending && route_smi;

  // R7: the two interrupt outputs are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !(irq && smi));
endmodule

// File: rtl/usbh_fstate_ctrl.sv
module usbh_fstate_ctrl
  import usbh_fs_pkg::*;
#(
  parameter int FRAME_CYCLES = 48000,
  parameter int DATA_W       = 8,
  parameter int N_EVT        = 4
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              resume_det,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              sof_pulse,
  output logic              bulk_active,
  output logic              irq,
  output logic              smi,
  output logic              hub_rst,
  output logic              ds_rst_req
);
  fstate_e state;
  logic    bulk_en, route_smi, sof_flag;
  logic    hub_rst_q;

  usbh_fs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .resume_det(resume_det), .sof(sof_pulse),
    .state(state), .bulk_en(bulk_en), .bulk_frame(bulk_active),
    .route_smi(route_smi), .sof_flag(sof_flag)
  );

  usbh_fs_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk(clk), .hw_rst_n(hw_rst_n), .in_oper(state == FS_OPER), .sof(sof_pulse)
  );

  usbh_fs_irq_route #(.N_EVT(N_EVT)) u_route (
    .clk(clk), .hw_rst_n(hw_rst_n), .evt_in(evt_in), .sof_flag(sof_flag),
    .route_smi(route_smi), .irq(irq), .smi(smi)
  );

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) hub_rst_q <= 1'b1;
    else           hub_rst_q <= 1'b0;
  end

  assign hub_rst    = hub_rst_q;
  assign ds_rst_req = (state == FS_RESET);

  // R5: the root-hub request ends after the first edge out of reset
  a_r5_hub_rst_ends: assert property (@(posedge clk) disable iff (!hw_rst_n)
    1'b1 |=> !hub_rst);
  // R6: downstream reset request drops once the machine leaves reset
  a_r6_ds_release: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (ds_rst_req && reg_wr && !reg_addr && reg_wdata[2:1] != 2'b00 && !sw_rst)
      |=> !ds_rst_req);
endmodule

// File: tb/usbh_fstate_ctrl_test.sv
module usbh_fstate_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int FC = 16;
  localparam int DW = 8;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic hw_rst_n = 1'b0;
  logic sw_rst = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0, resume_det = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic sof_pulse, bulk_active, irq, smi, hub_rst, ds_rst_req;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_fstate_ctrl #(.FRAME_CYCLES(FC), .DATA_W(DW), .N_EVT(NE)) uut (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .resume_det(resume_det), .evt_in(evt_in), .sof_pulse(sof_pulse),
    .bulk_active(bulk_active), .irq(irq), .smi(smi), .hub_rst(hub_rst),
    .ds_rst_req(ds_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ctrl word: [4] rwake, [3] route, [2:1] state, [0] bulk
  function automatic logic [DW-1:0] cw(input logic rw, input logic rt,
                                       input logic [1:0] st, input logic bk);
    cw = '0;
    cw[4:0] = {rw, rt, st, bk};
  endfunction

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_sof();
    for (int i = 0; i < 4*FC && !sof_pulse; i++) @(negedge clk);
    check("R2 strobe seen", sof_pulse, 1);
  endtask

  task automatic t_hw_reset();
    logic [DW-1:0] d;
    hw_rst_n = 1'b0; #1;
    check("R5 hub_rst in reset", hub_rst, 1);
    check("R6 ds_rst_req in reset", ds_rst_req, 1);
    rd(1'b0, d); check("R5 ctrl cleared", d, 0);
    rd(1'b1, d); check("R5 status cleared", d, 0);
    @(negedge clk); hw_rst_n = 1'b1;
    @(negedge clk);
    check("R5 hub_rst released", hub_rst, 0);
    check("R6 ds_rst_req still in reset", ds_rst_req, 1);
    check("R2 no strobe in reset", sof_pulse, 0);
  endtask

  task automatic t_leave_reset();
    logic [DW-1:0] d;
    wr(1'b0, cw(1'b1, 1'b0, 2'b01, 1'b0));
    check("R6 ds_rst_req released", ds_rst_req, 0);
    rd(1'b0, d); check("R1 readback resume", d, 8'h12);
  endtask

  task automatic t_first_frames();
    logic [DW-1:0] d;
    wr(1'b0, cw(1'b0, 1'b0, 2'b10, 1'b1));
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < FC; i++) begin
        if (f + i > 0) @(negedge clk);
        check("R2 strobe position", sof_pulse, (i == FC-1) ? 1 : 0);
      end
    @(negedge clk);
    rd(1'b1, d); check("R8 flag set", d[0], 1);
    check("R9 bulk latched", bulk_active, 1);
    check("R7 flag routed to irq", irq, 1);
  endtask

  task automatic t_bulk_clear();
    wait_sof();
    @(negedge clk);
    wr(1'b0, cw(1'b0, 1'b0, 2'b10, 1'b0));
    check("R9 bulk held mid-frame", bulk_active, 1);
    wait_sof();
    check("R9 bulk held on strobe cycle", bulk_active, 1);
    @(negedge clk);
    check("R9 bulk dropped after strobe", bulk_active, 0);
  endtask

  task automatic t_no_restart();
    wait_sof();
    for (int i = 1; i <= FC; i++) begin
      @(negedge clk);
      if (i == 3) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = cw(1'b0, 1'b0, 2'b10, 1'b0); end
      if (i == 4) begin reg_wr = 1'b0; reg_wdata = '0; end
      check("R2 rewrite keeps frame", sof_pulse, (i == FC) ? 1 : 0);
    end
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    wait_sof();
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R8 set wins over clear", d[0], 1);
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R8 write-1 clears", d[0], 0);
  endtask

  task automatic t_resume();
    logic [DW-1:0] d;
    resume_det = 1'b1; @(negedge clk); resume_det = 1'b0;
    rd(1'b0, d); check("R3 resume ignored in operational", d[2:1], 2'b10);
    wr(1'b0, cw(1'b0, 1'b0, 2'b11, 1'b0));
    check("R2 no strobe in suspend", sof_pulse, 0);
    resume_det = 1'b1; @(negedge clk); resume_det = 1'b0;
    rd(1'b0, d); check("R3 suspend to resume", d[2:1], 2'b01);
    resume_det = 1'b1; @(negedge clk); resume_det = 1'b0;
    rd(1'b0, d); check("R3 resume ignored in resume", d[2:1], 2'b01);
  endtask

  task automatic t_route();
    wr(1'b1, 8'h01);
    evt_in = '0; #1;
    check("R7 idle irq", irq, 0); check("R7 idle smi", smi, 0);
    evt_in = 4'b0100; #1;
    check("R7 normal irq", irq, 1); check("R7 normal smi", smi, 0);
    wr(1'b0, cw(1'b0, 1'b1, 2'b01, 1'b0));
    check("R7 smi routed", smi, 1); check("R7 irq off", irq, 0);
    evt_in = '0;
  endtask

  task automatic t_sw_reset();
    logic [DW-1:0] d;
    wr(1'b0, cw(1'b1, 1'b1, 2'b10, 1'b1));
    wait_sof();
    @(negedge clk);
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    rd(1'b0, d); check("R4 ctrl after sw reset", d, 8'h1E);
    rd(1'b1, d); check("R4 flag cleared", d, 0);
    check("R4 bulk frame cleared", bulk_active, 0);
    check("R4 no downstream reset", ds_rst_req, 0);
    check("R4 hub_rst untouched", hub_rst, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_hw_reset();
    t_leave_reset();
    t_first_frames();
    t_bulk_clear();
    t_no_restart();
    t_w1c();
    t_resume();
    t_route();
    t_sw_reset();
    t_hw_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule